// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a host bus and a configuration-space port. It presents two 4 KB windows, selected by host address bit 12: a selector window at 0 holding one 32-bit selector register, and a data window at 1. Software first writes a selector value describing the target function and register. It then reads or writes the data window. Each data-window access becomes exactly one configuration request on a downstream valid/ready port. The host waits until the matching response returns.

The selector can be written in three styles, and all of them are normalised into one standard configuration address. The first is a pass-through style flagged by the top bit. The second is a type-1 style flagged by bit 0. The third is a one-hot device-select style, in which the slot is the position of the lowest set bit above bit 10. Byte lanes are little-endian. The block also combines the four interrupt pins of every slot onto four shared interrupt lines using the usual rotating swizzle.

Top module: `cfg_xlate_top`

## Requirements
- R1: After reset the selector register reads as zero, no downstream request is valid, and each interrupt line is already the OR of its mapped pins.
- R2: A host write at any offset of the selector window (hostAddr[12]=0) stores all 32 bits of hostWdata. A read there returns the stored 32-bit value.
- R3: When selector bit 31 is 1, the request address is the selector with bits 1:0 replaced by hostAddr[1:0].
- R4: When selector bit 31 is 0 and bit 0 is 1, the request address is the selector with bits 2:0 replaced by hostAddr[2:0].
- R5: When selector bits 31 and 0 are both 0, the request address is built as follows. Bits 15:11 hold the slot, which is the index of the lowest set selector bit in 31:11, counted so that bit 11 gives slot 0. Bits 10:8 hold selector bits 10:8, bits 7:3 hold selector bits 7:3, and bits 2:0 hold hostAddr[2:0]. Bits 31:16 are zero.
- R6: In the R5 style with selector bits 31:11 all zero, no downstream request is issued. A read returns all ones masked to the access size, and a write is dropped.
- R7: Size code hostSize 0/1/2 means 1/2/4 bytes. The byte enables are 0x1/0x3/0xF shifted left by hostAddr[1:0] and truncated to 4 bits. The write data is hostWdata shifted left by 8*hostAddr[1:0], so that byte k of the value lands on lane offset+k.
- R8: Read data returned to the host is the response data shifted right by 8*hostAddr[1:0] and masked to the access size.
- R9: Each data-window access issues exactly one request. The request valid and its fields stay held until accepted by ready. hostAck is a one-cycle pulse after the response, or after a selector or no-device access.
- R10: Interrupt pin p of slot s is input bit s*4+p, and it drives line (s+p) mod 4. Lines 0..3 feed interrupt controller inputs 27, 28, 29 and 30 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request, held until hostAck |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 13 | Bit 12 selects data window; low bits are the window offset |
| hostSize | input | 2 | Access size code (0=1B, 1=2B, 2=4B) |
| hostWdata | input | 32 | Host write value, right-aligned |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read result, valid with hostAck |
| cfgReqValid | output | 1 | Downstream request valid |
| cfgReqReady | input | 1 | Downstream request accepted |
| cfgAddr | output | 32 | Normalised configuration address |
| cfgWrite | output | 1 | Request is a write |
| cfgBe | output | 4 | Byte enables |
| cfgWdata | output | 32 | Lane-aligned write data |
| cfgRspValid | input | 1 | Downstream response valid |
| cfgRspData | input | 32 | Downstream response data |
| devIntPin | input | 32 | Device interrupt pins, slot*4+pin |
| intLine | output | 4 | Swizzled interrupt lines |

## Verification
The assertions check the handshake rules on every cycle. A request held without ready stays valid, it drops after acceptance, the acknowledge lasts only one cycle, and a no-device access never raises a request. Quiet interrupt pins must also leave every line low. The bench scenarios cover the three selector styles, including the lowest-set-bit slot search, the lane shifts and masks for every size and offset, the response data alignment, and the full swizzle pattern. These are value relations that only known stimulus with computed expectations can show.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } ctrlState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic selLoad;     // store host write value into selector
    logic selRead;     // return selector value to host
    logic rspCapture;  // capture aligned response data
    logic missFill;    // return all-ones for an absent device
  } dpStrobe_t;

  function automatic logic [31:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] sizeLanes(input logic [1:0] sz);
    case (sz)
      2'd0:    sizeLanes = 4'b0001;
      2'd1:    sizeLanes = 4'b0011;
      default: sizeLanes = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cfg_xlate_datapath.sv
module cfg_xlate_datapath
  import cfg_xlate_pkg::*;
#(
  parameter int WIN_BITS = 12,
  parameter int SLOT_LSB = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [WIN_BITS:0]   hostAddr,
  input  logic [1:0]          hostSize,
  input  logic [31:0]         hostWdata,
  input  logic [31:0]         cfgRspData,
  output logic                isDataWin,
  output logic                noDevice,
  output logic [31:0]         cfgAddr,
  output logic [3:0]          cfgBe,
  output logic [31:0]         cfgWdata,
  output logic [31:0]         hostRdata
);

  localparam int SEL_SPAN = 32 - SLOT_LSB;

  logic [31:0] selQ;
  logic [31:0] rdataQ;
  logic [4:0]  slotNum;
  logic        slotHit;
  logic        modePass;
  logic        modeType1;
  logic [1:0]  laneOff;
  logic [31:0] accMask;

  assign isDataWin = hostAddr[WIN_BITS];
  assign laneOff   = hostAddr[1:0];
  assign accMask   = sizeMask(hostSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (strobe.selLoad) begin
      selQ <= hostWdata;
    end
  end

  // lowest set bit search: descending scan so the lowest hit wins
  always_comb begin
    slotNum = '0;
    slotHit = 1'b0;
    for (int b = SEL_SPAN - 1; b >= 0; b--) begin
      if (selQ[SLOT_LSB + b]) begin
        slotNum = 5'(b);
        slotHit = 1'b1;
      end
    end
  end

  assign modePass  = selQ[31];
  assign modeType1 = !selQ[31] && selQ[0];
  assign noDevice  = !modePass && !modeType1 && !slotHit;

  always_comb begin
    if (modePass) begin
      cfgAddr = {selQ[31:2], hostAddr[1:0]};
    end else if (modeType1) begin
      cfgAddr = {selQ[31:3], hostAddr[2:0]};
    end else begin
      cfgAddr = {16'h0000, slotNum, selQ[10:8], selQ[7:3], hostAddr[2:0]};
    end
  end

  assign cfgBe    = sizeLanes(hostSize) << laneOff;
  assign cfgWdata = hostWdata << {laneOff, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.selRead) begin
      rdataQ <= selQ;
    end else if (strobe.missFill) begin
      rdataQ <= accMask;
    end else if (strobe.rspCapture) begin
      rdataQ <= (cfgRspData >> {laneOff, 3'b000}) & accMask;
    end
  end

  assign hostRdata = rdataQ;

endmodule

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostReq,
  input  logic      hostWr,
  input  logic      isDataWin,
  input  logic      noDevice,
  input  logic      cfgReqReady,
  input  logic      cfgRspValid,
  output dpStrobe_t strobe,
  output logic      cfgReqValid,
  output logic      hostAck
);

  ctrlState_t stateQ;
  ctrlState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateNext;
    end
  end

  always_comb begin
    stateNext   = stateQ;
    strobe      = '0;
    cfgReqValid = 1'b0;
    hostAck     = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (hostReq) begin
          if (!isDataWin) begin
            strobe.selLoad = hostWr;
            strobe.selRead = !hostWr;
            stateNext      = ST_ACK;
          end else if (noDevice) begin
            strobe.missFill = !hostWr;
            stateNext       = ST_ACK;
          end else begin
            stateNext = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        cfgReqValid = 1'b1;
        if (cfgReqReady) begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cfgRspValid) begin
          strobe.rspCapture = !hostWr;
          stateNext         = ST_ACK;
        end
      end
      default: begin
        hostAck   = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && !cfgReqReady |=> cfgReqValid); // R9

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && cfgReqReady |=> !cfgReqValid); // R9

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck); // R9

  AST_MISS_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) && hostReq && isDataWin && noDevice |=> !cfgReqValid); // R6

endmodule

// File: rtl/cfg_xlate_irq.sv
module cfg_xlate_irq #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_PINS  = 4
) (
  input  logic [NUM_SLOTS*NUM_PINS-1:0] devIntPin,
  output logic [NUM_PINS-1:0]           intLine
);

  for (genvar l = 0; l < NUM_PINS; l++) begin : g_line
    logic lineHit;
    always_comb begin
      lineHit = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (((s + p) % NUM_PINS) == l) begin
            lineHit = lineHit | devIntPin[s*NUM_PINS + p];
          end
        end
      end
    end
    assign intLine[l] = lineHit;
  end

  always_comb begin
    if (devIntPin == '0) begin
      AST_LINE_QUIET: assert (intLine == '0); // R10
    end
  end

endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
#(
  parameter int WIN_BITS  = 12,
  parameter int NUM_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostReq,
  input  logic                   hostWr,
  input  logic [WIN_BITS:0]      hostAddr,
  input  logic [1:0]             hostSize,
  input  logic [31:0]            hostWdata,
  output logic                   hostAck,
  output logic [31:0]            hostRdata,
  output logic                   cfgReqValid,
  input  logic                   cfgReqReady,
  output logic [31:0]            cfgAddr,
  output logic                   cfgWrite,
  output logic [3:0]             cfgBe,
  output logic [31:0]            cfgWdata,
  input  logic                   cfgRspValid,
  input  logic [31:0]            cfgRspData,
  input  logic [NUM_SLOTS*4-1:0] devIntPin,
  output logic [3:0]             intLine
);

  dpStrobe_t strobe;
  logic      isDataWin;
  logic      noDevice;

  assign cfgWrite = hostWr;

  cfg_xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostReq     (hostReq),
    .hostWr      (hostWr),
    .isDataWin   (isDataWin),
    .noDevice    (noDevice),
    .cfgReqReady (cfgReqReady),
    .cfgRspValid (cfgRspValid),
    .strobe      (strobe),
    .cfgReqValid (cfgReqValid),
    .hostAck     (hostAck)
  );

  cfg_xlate_datapath #(.WIN_BITS(WIN_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostAddr   (hostAddr),
    .hostSize   (hostSize),
    .hostWdata  (hostWdata),
    .cfgRspData (cfgRspData),
    .isDataWin  (isDataWin),
    .noDevice   (noDevice),
    .cfgAddr    (cfgAddr),
    .cfgBe      (cfgBe),
    .cfgWdata   (cfgWdata),
    .hostRdata  (hostRdata)
  );

  cfg_xlate_irq #(.NUM_SLOTS(NUM_SLOTS), .NUM_PINS(4)) u_irq (
    .devIntPin (devIntPin),
    .intLine   (intLine)
  );

endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_top_tb_top;

  localparam int NSLOT = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hostReq = 1'b0;
  logic             hostWr = 1'b0;
  logic [12:0]      hostAddr = '0;
  logic [1:0]       hostSize = '0;
  logic [31:0]      hostWdata = '0;
  logic             hostAck;
  logic [31:0]      hostRdata;
  logic             cfgReqValid;
  logic             cfgReqReady = 1'b0;
  logic [31:0]      cfgAddr;
  logic             cfgWrite;
  logic [3:0]       cfgBe;
  logic [31:0]      cfgWdata;
  logic             cfgRspValid = 1'b0;
  logic [31:0]      cfgRspData = '0;
  logic [NSLOT*4-1:0] devIntPin = '0;
  logic [3:0]       intLine;

  int total = 0;
  int bad = 0;
  int reqCount = 0;
  logic [31:0] logAddr, logWdata;
  logic [3:0]  logBe;
  logic        logWr;

  always #5 clk = ~clk;

  cfg_xlate_top #(.WIN_BITS(12), .NUM_SLOTS(NSLOT)) dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostAck(hostAck), .hostRdata(hostRdata), .cfgReqValid(cfgReqValid),
    .cfgReqReady(cfgReqReady), .cfgAddr(cfgAddr), .cfgWrite(cfgWrite),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata), .cfgRspValid(cfgRspValid),
    .cfgRspData(cfgRspData), .devIntPin(devIntPin), .intLine(intLine)
  );

  function automatic logic [31:0] respFn(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] sel, input logic [2:0] off);
    int slot;
    if (sel[31]) return {sel[31:2], off[1:0]};
    if (sel[0])  return {sel[31:3], off};
    slot = 0;
    for (int b = 30; b >= 11; b--) if (sel[b]) slot = b - 11;
    return {16'h0, 5'(slot), sel[10:8], sel[7:3], off};
  endfunction

  function automatic logic [31:0] expMask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] expBe(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] base;
    base = (sz == 2'd0) ? 4'h1 : (sz == 2'd1) ? 4'h3 : 4'hF;
    return base << off;
  endfunction

  function automatic logic [3:0] expLines(input logic [NSLOT*4-1:0] pins);
    logic [3:0] r;
    r = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < 4; p++)
        if (pins[s*4+p]) r[(s+p)%4] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // downstream responder with random latencies
  initial begin
    forever begin
      @(negedge clk);
      if (cfgReqValid) begin
        repeat ($urandom % 3) @(negedge clk);
        cfgReqReady = 1'b1;
        logAddr = cfgAddr; logWr = cfgWrite; logBe = cfgBe; logWdata = cfgWdata;
        reqCount++;
        @(negedge clk);
        cfgReqReady = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        cfgRspValid = 1'b1;
        cfgRspData  = respFn(logAddr);
        @(negedge clk);
        cfgRspValid = 1'b0;
      end
    end
  end

  task automatic access(input logic wr, input logic [12:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    hostWr = wr; hostAddr = a; hostSize = sz; hostWdata = wd; hostReq = 1'b1;
    forever begin
      @(negedge clk);
      if (hostAck) break;
    end
    rd = hostRdata;
    hostReq = 1'b0;
  endtask

  task automatic setSel(input logic [31:0] v);
    logic [31:0] rd;
    access(1'b1, 13'h0000, 2'd2, v, rd);
  endtask

  task automatic dataCheck(input string tag, input logic wr, input logic [2:0] off,
                           input logic [1:0] sz, input logic [31:0] sel, input logic [31:0] wd);
    logic [31:0] rd;
    logic [12:0] a;
    int pre;
    a = {1'b1, 9'($urandom), off};
    pre = reqCount;
    access(wr, a, sz, wd, rd);
    chk({tag, " R9 one request"}, 32'(reqCount), 32'(pre + 1));
    chk({tag, " addr"}, logAddr, expAddr(sel, off));
    chk({tag, " R7 be"}, 32'(logBe), 32'(expBe(sz, off[1:0])));
    chk({tag, " R9 write flag"}, 32'(logWr), 32'(wr));
    if (wr) chk({tag, " R7 wdata"}, logWdata, wd << (8 * off[1:0]));
    else    chk({tag, " R8 rdata"}, rd,
                (respFn(expAddr(sel, off)) >> (8 * off[1:0])) & expMask(sz));
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, sel;
    int pre;
    void'($urandom(32'd20240));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 no request", 32'(cfgReqValid), 32'd0);
    chk("R1 lines idle", 32'(intLine), 32'd0);
    access(1'b0, 13'h0000, 2'd2, 32'h0, rd);
    chk("R1 selector zero", rd, 32'h0);

    // R2 selector write/read at various offsets
    access(1'b1, 13'h0ABC, 2'd0, 32'hDEAD_BEEF, rd);
    access(1'b0, 13'h0004, 2'd0, 32'h0, rd);
    chk("R2 selector readback", rd, 32'hDEAD_BEEF);

    // R6 one-hot with no slot bit: reads and writes
    setSel(32'h0000_07F8);
    pre = reqCount;
    access(1'b0, 13'h1001, 2'd0, 32'h0, rd);
    chk("R6 miss byte ones", rd, 32'h0000_00FF);
    access(1'b0, 13'h1002, 2'd1, 32'h0, rd);
    chk("R6 miss half ones", rd, 32'h0000_FFFF);
    access(1'b1, 13'h1000, 2'd2, 32'h1234_5678, rd);
    chk("R6 no request issued", 32'(reqCount), 32'(pre));
    access(1'b0, 13'h0000, 2'd2, 32'h0, rd);
    chk("R6 selector untouched", rd, 32'h0000_07F8);

    // R3 pass-through style
    setSel(32'h8000_1234);
    dataCheck("R3 pass", 1'b0, 3'd3, 2'd0, 32'h8000_1234, 32'h0);
    chk("R3 addr literal", logAddr, 32'h8000_1237);
    // R4 type-1 style
    setSel(32'h00A5_1601);
    dataCheck("R4 type1", 1'b1, 3'd6, 2'd1, 32'h00A5_1601, 32'h0000_CAFE);
    chk("R4 addr literal", logAddr, 32'h00A5_1606);
    // R5 highest one-hot slot (bit 30 -> slot 19) and lowest (bit 11)
    setSel(32'h4000_05A8);
    dataCheck("R5 slot19", 1'b0, 3'd4, 2'd2, 32'h4000_05A8, 32'h0);
    chk("R5 addr literal", logAddr, 32'h0000_9DAC);
    setSel(32'h7FFF_FB30);
    dataCheck("R5 lowest wins", 1'b1, 3'd1, 2'd0, 32'h7FFF_FB30, 32'h0000_0077);
    chk("R5 slot0 literal", logAddr, 32'h0000_0331);

    // random mix across styles, sizes, offsets
    for (int it = 0; it < 60; it++) begin
      int mode;
      logic [1:0] sz;
      logic [2:0] off;
      logic wr;
      mode = $urandom % 3;
      sel = $urandom;
      if (mode == 0) sel[31] = 1'b1;
      else if (mode == 1) begin sel[31] = 1'b0; sel[0] = 1'b1; end
      else begin
        sel = sel & 32'h7FFF_FFFE;
        sel[11 + ($urandom % 20)] = 1'b1;
      end
      setSel(sel);
      access(1'b0, 13'(($urandom % 4096) & 32'hFFC), 2'd2, 32'h0, rd);
      chk("R2 random readback", rd, sel);
      sz = 2'($urandom % 3);
      off = 3'($urandom);
      wr = 1'($urandom);
      case (mode)
        0: dataCheck("R3 rand", wr, off, sz, sel, $urandom);
        1: dataCheck("R4 rand", wr, off, sz, sel, $urandom);
        default: dataCheck("R5 rand", wr, off, sz, sel, $urandom);
      endcase
    end

    // R10 interrupt swizzle
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < 4; p++) begin
        devIntPin = '0;
        devIntPin[s*4+p] = 1'b1;
        #1;
        chk("R10 single pin", 32'(intLine), 32'(4'b0001 << ((s + p) % 4)));
      end
    end
    for (int it = 0; it < 20; it++) begin
      devIntPin = $urandom & $urandom;
      #1;
      chk("R10 random pins", 32'(intLine), 32'(expLines(devIntPin)));
    end
    devIntPin = '0;
    #1;
    chk("R10 all quiet", 32'(intLine), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule